// File: doc/BRIEF.md
# Ethernet Receive Frame Queue

This block holds received Ethernet frames until software collects them. Frames arrive as a byte stream with valid, last and ready. Each accepted frame goes into one of `SLOTS` fixed-size slots. The slots form a ring. The stored image of a frame has three parts:

- a 16-bit length header;
- the payload bytes;
- a CRC-32 that the block computes one byte per cycle as the payload streams in.

Software drains the queue through a small register port. Each read of the data register returns the next 32-bit word of the oldest frame. When the last word of that frame has been read, the block moves on to the next frame by itself. The block also keeps sticky status bits for a received frame and for a frame dropped as too long, raises an interrupt from them, and exposes the number of pending frames.

The default geometry is 31 slots of 64 bytes, which keeps the storage small. The slot size is a parameter and may be any power of two up to 64 KiB, for example 2048 bytes for full-size frames.

The register map uses word addresses:

| Address | Register | Read | Write |
|---|---|---|---|
| 0 | status | bit 0 received, bit 1 overflow | write 1 to clear a bit |
| 1 | control | bit 0 enable | bit 0 enable, bit 1 flush (self-clearing) |
| 2 | data | next stored word | no effect |
| 3 | count | pending-frame count | no effect |

A register read returns its value on `reg_rdata` in the cycle after `reg_rd` is high.

Top module: `eth_rx_frame_queue`

## Requirements
- R1: The queue holds at most `SLOTS` (31) frames in a ring. A new frame goes to slot (read index + count) mod `SLOTS`. Frames are read back in arrival order, including across the wrap of the ring.
- R2: When the enable bit (control bit 0) is set and the count equals `SLOTS`, `in_ready` is low at the start of a frame. A frame that starts while the enable bit is clear is consumed with `in_ready` high and discarded. A discarded frame changes neither the count nor the status.
- R3: A frame with a payload of `SLOT_BYTES`-6 bytes or more (58 with the defaults) is dropped. The drop sets status bit 1 and leaves the count unchanged. A payload one byte shorter than that limit is stored.
- R4: The stored image of a frame is laid out as follows:
  - stored byte 0 and byte 1 hold the value payload+6, least significant byte first;
  - the payload follows from byte 2;
  - the four CRC bytes come last, least significant byte first;
  - a data word carries stored byte 4w+k in bits [8k+7:8k].
- R5: The CRC is the Ethernet CRC-32 of the payload: reflected polynomial 0xEDB88320, initial value all ones, result inverted.
- R6: Any byte lanes of a frame's final word that lie beyond its stored length read as zero.
- R7: Every stored frame sets status bit 0. `irq` is the OR of the status bits. Writing 1 to a status bit clears that bit.
- R8: Each data read returns the next word and advances the read offset by 4. When the offset plus 4 reaches the stored length, the read offset returns to 0, the read index advances (wrapping at `SLOTS`), and the count drops by one.
- R9: A data read while the count is zero returns 0 and changes no state.
- R10: Writing control bit 1 set clears the count and the read offset, keeps the read index, and drops any frame still being received.
- R11: The count register returns the number of pending frames. When a frame is stored in the same cycle that a read finishes another frame, both changes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The byte is the last of its frame |
| in_ready | output | 1 | The block takes the byte at this edge |
| reg_addr | input | 2 | Register word address (0 status, 1 control, 2 data, 3 count) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt: any status bit set |

## Verification
Payloads of one to five bytes are used to place the CRC and the zero fill at every byte-lane offset, which separates a wrong lane shift from a wrong fill. Payloads of exactly the limit length and one byte below it tell a dropped frame from a stored one. A run of 31 frames fills the ring, shows the input stall, and then drains the frames across the wrap of the read index. Further stimuli cover:

- a flush that lands in the middle of a frame being read;
- a data read that finishes one frame in the same cycle that another frame is stored, which tells a lost count update from a correct one.

// File: rtl/erq_pkg.sv
package erq_pkg;

   typedef enum logic [2:0] {
      W_IDLE,
      W_DATA,
      W_CRC,
      W_FLUSH,
      W_HDR
   } wr_state_e;

   localparam logic [1:0] A_STATUS = 2'd0;
   localparam logic [1:0] A_CTRL   = 2'd1;
   localparam logic [1:0] A_DATA   = 2'd2;
   localparam logic [1:0] A_COUNT  = 2'd3;

   localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

   // One byte step of the reflected CRC-32.
   function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      r = c ^ {24'd0, b};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/erq_store.sv
module erq_store #(
   parameter int SLOTS      = 31,
   parameter int SLOT_BYTES = 64
) (
   input  logic                                               clk,
   input  logic                                               wr_en,
   input  logic [$clog2(SLOTS)+$clog2(SLOT_BYTES/4)-1:0]      wr_addr,
   input  logic [31:0]                                        wr_word,
   input  logic [$clog2(SLOTS)+$clog2(SLOT_BYTES/4)-1:0]      rd_addr,
   output logic [31:0]                                        rd_word,
   input  logic [$clog2(SLOTS)+$clog2(SLOT_BYTES/4)-1:0]      hdr_addr,
   output logic [15:0]                                        hdr_len
);
   localparam int WPS   = SLOT_BYTES / 4;
   localparam int AW    = $clog2(SLOTS) + $clog2(WPS);
   localparam int DEPTH = 1 << AW;

   logic [31:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_word;
   end

   assign rd_word = mem[rd_addr];
   assign hdr_len = mem[hdr_addr][15:0];
endmodule

// File: rtl/erq_writer.sv
module erq_writer
   import erq_pkg::*;
#(
   parameter int SLOTS      = 31,
   parameter int SLOT_BYTES = 64
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic [7:0]                                    in_data,
   input  logic                                          in_valid,
   input  logic                                          in_last,
   output logic                                          in_ready,
   input  logic                                          rx_en,
   input  logic                                          full,
   input  logic                                          flush,
   input  logic [$clog2(SLOTS)-1:0]                      base_slot,
   output logic                                          wr_en,
   output logic [$clog2(SLOTS)+$clog2(SLOT_BYTES/4)-1:0] wr_addr,
   output logic [31:0]                                   wr_word,
   output logic                                          commit,
   output logic                                          ovf_evt
);
   localparam int WPS   = SLOT_BYTES / 4;
   localparam int WW    = $clog2(WPS);
   localparam int SW    = $clog2(SLOTS);
   localparam int PW    = WW + 3;
   localparam int LIMIT = SLOT_BYTES - 6;

   wr_state_e      st_q;
   logic [SW-1:0]  slot_q, cur_slot;
   logic [PW-1:0]  pos_q;
   logic [31:0]    acc_q, acc_new, crc_q, crc_fin;
   logic [15:0]    hdr_q;
   logic           drop_q, ovf_q;
   logic [1:0]     k_q, lane;
   logic [WW-1:0]  word_idx;
   logic [7:0]     put_byte;
   logic           take, first, base_drop, ovf_hit, drop_now, put_en, restart;

   assign in_ready  = (st_q == W_IDLE) ? !(rx_en && full) : (st_q == W_DATA);
   assign take      = in_valid && in_ready;
   assign first     = (st_q == W_IDLE);
   assign base_drop = first ? !rx_en : drop_q;
   assign ovf_hit   = take && !base_drop && (pos_q == PW'(LIMIT + 1));
   assign drop_now  = base_drop || ovf_hit || flush;
   assign cur_slot  = first ? base_slot : slot_q;

   assign crc_fin   = ~crc_q;
   assign put_en    = (take && !drop_now) || (st_q == W_CRC && !flush);
   assign put_byte  = (st_q == W_CRC) ? crc_fin[8*k_q +: 8] : in_data;
   assign lane      = pos_q[1:0];
   assign word_idx  = pos_q[WW+1:2];
   assign acc_new   = ((lane == 2'd0) ? 32'd0 : acc_q) | ({24'd0, put_byte} << {lane, 3'b000});

   assign ovf_evt   = take && in_last && (ovf_q || ovf_hit);
   assign restart   = (take && in_last && drop_now)
                    || ((st_q == W_CRC || st_q == W_FLUSH) && flush)
                    || (st_q == W_HDR);

   always_comb begin
      wr_en   = 1'b0;
      wr_addr = {cur_slot, word_idx};
      wr_word = acc_new;
      commit  = 1'b0;
      if (put_en && lane == 2'd3 && word_idx != '0) wr_en = 1'b1;
      if (st_q == W_FLUSH && lane != 2'd0 && !flush) begin
         wr_en   = 1'b1;
         wr_word = acc_q;
      end
      if (st_q == W_HDR && !flush) begin
         wr_en   = 1'b1;
         wr_addr = {slot_q, WW'(0)};
         wr_word = {hdr_q, 16'(pos_q)};
         commit  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= W_IDLE;
         slot_q <= '0;
         pos_q  <= PW'(2);
         acc_q  <= '0;
         hdr_q  <= '0;
         crc_q  <= '1;
         drop_q <= 1'b0;
         ovf_q  <= 1'b0;
         k_q    <= '0;
      end else begin
         if (put_en) begin
            acc_q <= acc_new;
            pos_q <= pos_q + 1'b1;
            if (lane == 2'd3 && word_idx == '0) hdr_q <= acc_new[31:16];
         end
         if (take) begin
            crc_q  <= crc32_byte(first ? 32'hFFFF_FFFF : crc_q, in_data);
            slot_q <= cur_slot;
         end
         case (st_q)
            W_IDLE, W_DATA: begin
               if (take) begin
                  if (in_last) begin
                     st_q <= W_CRC;
                     k_q  <= '0;
                  end else begin
                     st_q   <= W_DATA;
                     drop_q <= drop_now;
                     ovf_q  <= ovf_q || ovf_hit;
                  end
               end else if (st_q == W_DATA && flush) begin
                  drop_q <= 1'b1;
               end
            end
            W_CRC: begin
               k_q <= k_q + 1'b1;
               if (k_q == 2'd3) st_q <= W_FLUSH;
            end
            W_FLUSH: st_q <= W_HDR;
            default: st_q <= W_IDLE;
         endcase
         if (restart) begin
            st_q   <= W_IDLE;
            pos_q  <= PW'(2);
            acc_q  <= '0;
            drop_q <= 1'b0;
            ovf_q  <= 1'b0;
         end
      end
   end

   // R3: a frame dropped for length is never committed
   a_r3_drop_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |-> !commit && (st_q == W_IDLE || st_q == W_DATA));

   // R4: a committed header carries a length of payload+6 that fits its slot
   a_r4_hdr_len: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (wr_word[15:0] >= 16'd7) && (wr_word[15:0] < 16'(SLOT_BYTES)));

   // R2: no byte is taken while the ring is full and a new frame would start
   a_r2_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (take && first && rx_en) |-> !full);
endmodule

// File: rtl/erq_reader.sv
module erq_reader #(
   parameter int SLOTS      = 31,
   parameter int SLOT_BYTES = 64
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          rd_stb,
   input  logic                                          flush,
   input  logic [$clog2(SLOTS+1)-1:0]                    count,
   input  logic [15:0]                                   hdr_len,
   input  logic [31:0]                                   mem_word,
   output logic [$clog2(SLOTS)+$clog2(SLOT_BYTES/4)-1:0] rd_addr,
   output logic [$clog2(SLOTS)+$clog2(SLOT_BYTES/4)-1:0] hdr_addr,
   output logic [$clog2(SLOTS)-1:0]                      rd_idx,
   output logic                                          pop,
   output logic [31:0]                                   rd_data
);
   localparam int WW = $clog2(SLOT_BYTES / 4);
   localparam int SW = $clog2(SLOTS);
   localparam int PW = WW + 3;

   logic [SW-1:0] idx_q;
   logic [PW-1:0] off_q;
   logic          live, at_end;

   assign live     = rd_stb && !flush && (count != '0);
   assign at_end   = ({1'b0, 16'(off_q)} + 17'd4) >= {1'b0, hdr_len};
   assign pop      = live && at_end;
   assign rd_addr  = {idx_q, off_q[WW+1:2]};
   assign hdr_addr = {idx_q, WW'(0)};
   assign rd_idx   = idx_q;
   assign rd_data  = (count != '0) ? mem_word : 32'd0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         off_q <= '0;
      end else if (flush) begin
         off_q <= '0;
      end else if (live) begin
         if (at_end) begin
            off_q <= '0;
            idx_q <= (idx_q == SW'(SLOTS - 1)) ? '0 : idx_q + 1'b1;
         end else begin
            off_q <= off_q + PW'(4);
         end
      end
   end

   // R8: finishing a frame moves the read index on by one, wrapping at SLOTS
   a_r8_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> idx_q == (($past(idx_q) == SW'(SLOTS - 1)) ? '0 : $past(idx_q) + 1'b1));

   // R9: a data read on an empty queue leaves the read state alone
   a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !flush && count == '0) |=> $stable(idx_q) && $stable(off_q));

   // R10: a flush returns the read offset to the frame start
   a_r10_offset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> off_q == '0 && $stable(idx_q));
endmodule

// File: rtl/eth_rx_frame_queue.sv
module eth_rx_frame_queue
   import erq_pkg::*;
#(
   parameter int SLOTS      = 31,
   parameter int SLOT_BYTES = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  in_data,
   input  logic        in_valid,
   input  logic        in_last,
   output logic        in_ready,
   input  logic [1:0]  reg_addr,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   input  logic        reg_rd,
   output logic [31:0] reg_rdata,
   output logic        irq
);
   localparam int WW = $clog2(SLOT_BYTES / 4);
   localparam int SW = $clog2(SLOTS);
   localparam int CW = $clog2(SLOTS + 1);
   localparam int AW = SW + WW;

   generate
      if (SLOT_BYTES < 16 || (SLOT_BYTES & (SLOT_BYTES - 1)) != 0) begin : g_bad_slot
         $error("SLOT_BYTES must be a power of two of at least 16");
      end
      if (SLOT_BYTES > 65536) begin : g_big_slot
         $error("SLOT_BYTES must fit the 16-bit length header");
      end
      if (SLOTS < 2) begin : g_few_slots
         $error("SLOTS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [1:0]    sts_q;
   logic          en_q;
   logic [31:0]   rdata_q;

   logic          flush, rd_stb, commit, ovf_evt, pop, wr_en;
   logic [AW-1:0] wr_addr, rd_addr, hdr_addr;
   logic [31:0]   wr_word, mem_word, rd_data;
   logic [15:0]   hdr_len;
   logic [SW-1:0] rd_idx, base_slot;
   logic [SW:0]   slot_sum;
   logic          unused_wdata;

   assign unused_wdata = ^reg_wdata[31:2];
   assign flush        = reg_wr && reg_addr == A_CTRL && reg_wdata[1];
   assign rd_stb       = reg_rd && reg_addr == A_DATA;
   assign slot_sum     = {1'b0, rd_idx} + (SW + 1)'(cnt_q);
   assign base_slot    = (slot_sum >= (SW + 1)'(SLOTS)) ? SW'(slot_sum - (SW + 1)'(SLOTS))
                                                         : SW'(slot_sum);

   erq_writer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
      .clk(clk), .rst_n(rst_n),
      .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .rx_en(en_q), .full(cnt_q == CW'(SLOTS)), .flush(flush), .base_slot(base_slot),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
      .commit(commit), .ovf_evt(ovf_evt)
   );

   erq_store #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
      .rd_addr(rd_addr), .rd_word(mem_word), .hdr_addr(hdr_addr), .hdr_len(hdr_len)
   );

   erq_reader #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_reader (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .flush(flush), .count(cnt_q),
      .hdr_len(hdr_len), .mem_word(mem_word), .rd_addr(rd_addr), .hdr_addr(hdr_addr),
      .rd_idx(rd_idx), .pop(pop), .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         sts_q   <= '0;
         en_q    <= 1'b0;
         rdata_q <= '0;
      end else begin
         if (flush)                cnt_q <= '0;
         else if (commit && !pop)  cnt_q <= cnt_q + 1'b1;
         else if (pop && !commit)  cnt_q <= cnt_q - 1'b1;

         if (reg_wr && reg_addr == A_CTRL) en_q <= reg_wdata[0];

         sts_q[0] <= (sts_q[0] && !(reg_wr && reg_addr == A_STATUS && reg_wdata[0])) || commit;
         sts_q[1] <= (sts_q[1] && !(reg_wr && reg_addr == A_STATUS && reg_wdata[1])) || ovf_evt;

         if (reg_rd) begin
            case (reg_addr)
               A_STATUS: rdata_q <= {30'd0, sts_q};
               A_CTRL:   rdata_q <= {31'd0, en_q};
               A_DATA:   rdata_q <= rd_data;
               default:  rdata_q <= 32'(cnt_q);
            endcase
         end
      end
   end

   assign reg_rdata = rdata_q;
   assign irq       = |sts_q;

   // R1: the pending count never exceeds the ring size
   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(SLOTS));

   // R7: a stored frame sets the receive status bit
   a_r7_rx_status: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> sts_q[0]);

   // R3: a length drop sets the overflow status bit
   a_r3_ovf_status: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> sts_q[1]);

   // R10: a flush empties the queue
   a_r10_flush_count: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt_q == '0);

   // R11: store and frame-finish in one cycle leave the count unchanged
   a_r11_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && pop && !flush) |=> $stable(cnt_q));
endmodule

// File: tb/eth_rx_frame_queue_test.sv
module eth_rx_frame_queue_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_last = 1'b0;
   logic        in_ready;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_checks = 0;
   int n_errs   = 0;
   logic [31:0] exp_q[$];

   always #5 clk = ~clk;

   eth_rx_frame_queue uut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
      .in_ready(in_ready), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input logic [7:0] p[256], input int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         c ^= {24'd0, p[i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   // Driver: sends a frame and, when it should be stored, pushes its image.
   task automatic send_frame(input int n, input int seed, input bit stored);
      logic [7:0] p[256];
      logic [7:0] img[264];
      logic [31:0] crc;
      int total;
      for (int i = 0; i < n; i++) p[i] = 8'(seed + i * 37 + 3);
      if (stored) begin
         crc   = ref_crc(p, n);
         total = n + 6;
         for (int i = 0; i < 264; i++) img[i] = 8'd0;
         img[0] = 8'(total);
         img[1] = 8'(total >> 8);
         for (int i = 0; i < n; i++) img[2 + i] = p[i];
         for (int k = 0; k < 4; k++) img[2 + n + k] = crc[8*k +: 8];
         for (int w = 0; w < (total + 3) / 4; w++)
            exp_q.push_back({img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]});
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = p[i]; in_last = (i == n - 1);
         while (!in_ready) @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   task automatic read_word(input string req);
      logic [31:0] v, e;
      reg_read(2'd2, v);
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
      chk(req, v, e);
   endtask

   // Monitor: drains one frame, using its header to know the word count.
   task automatic drain_one(input string req);
      logic [31:0] v, e;
      int nw;
      reg_read(2'd2, v);
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
      chk(req, v, e);
      nw = (int'(e[15:0]) + 3) / 4;
      if (nw > 16) nw = 16;
      for (int w = 1; w < nw; w++) read_word(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state
      reg_read(2'd3, v); chk("R11 reset count", v, 0);
      reg_read(2'd0, v); chk("R7 reset status", v, 0);
      chk("R7 reset irq", 32'(irq), 0);

      // R9: read on empty queue
      reg_read(2'd2, v); chk("R9 empty read data", v, 0);
      reg_read(2'd3, v); chk("R9 empty read count", v, 0);

      // R2: disabled input is consumed and discarded
      send_frame(5, 11, 1'b0); settle();
      reg_read(2'd3, v); chk("R2 disabled count", v, 0);
      reg_read(2'd0, v); chk("R2 disabled status", v, 0);

      // R4 R5 R6: every lane offset of the tail
      reg_write(2'd1, 32'd1);
      for (int n = 1; n <= 5; n++) begin send_frame(n, n * 5, 1'b1); settle(); end
      reg_read(2'd3, v); chk("R11 count after five", v, 5);
      reg_read(2'd0, v); chk("R7 rx status", v, 1);
      chk("R7 irq high", 32'(irq), 1);
      for (int n = 1; n <= 5; n++) drain_one("R4 R5 R6 R8 frame image");
      reg_read(2'd3, v); chk("R8 count drained", v, 0);
      reg_write(2'd0, 32'd1);
      chk("R7 irq cleared", 32'(irq), 0);

      // R3: length limit
      send_frame(58, 9, 1'b0); settle();
      reg_read(2'd0, v); chk("R3 overflow status", v, 2);
      reg_read(2'd3, v); chk("R3 overflow count", v, 0);
      send_frame(57, 21, 1'b1); settle();
      reg_read(2'd3, v); chk("R3 longest stored count", v, 1);
      drain_one("R3 longest frame image");
      reg_write(2'd0, 32'd3);

      // R1 R2: fill the ring, stall, then drain across the wrap
      for (int i = 0; i < 31; i++) begin send_frame(1 + i % 4, i * 13, 1'b1); settle(); end
      reg_read(2'd3, v); chk("R1 full count", v, 31);
      fork
         send_frame(3, 77, 1'b1);
         begin
            repeat (4) @(negedge clk);
            chk("R2 stall when full", 32'(in_ready), 0);
            drain_one("R1 oldest frame");
         end
      join
      settle();
      reg_read(2'd3, v); chk("R1 count after refill", v, 31);
      for (int i = 0; i < 31; i++) drain_one("R1 ring order");
      reg_read(2'd3, v); chk("R1 ring empty", v, 0);

      // R10: flush in the middle of a frame
      send_frame(6, 40, 1'b1); settle();
      send_frame(2, 41, 1'b1); settle();
      read_word("R10 word before flush");
      reg_write(2'd1, 32'd3);
      exp_q.delete();
      reg_read(2'd3, v); chk("R10 flush count", v, 0);
      send_frame(4, 50, 1'b1); settle();
      drain_one("R10 frame after flush");

      // R11: frame finishes on the same edge a new frame is stored
      send_frame(1, 60, 1'b1); settle();
      read_word("R11 first word");
      send_frame(2, 61, 1'b1);
      repeat (4) @(negedge clk);
      read_word("R11 finishing word");
      settle();
      reg_read(2'd3, v); chk("R11 same-cycle count", v, 1);
      drain_one("R11 later frame");

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end
endmodule